// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Acknowledge

This block gathers up to `NSRC` interrupt inputs and drives a single processor interrupt line. Software configures it through a plain 32-bit register bus. Each source has a 5-bit priority, an enable, a target byte and a trigger mode. The controller keeps finding the most urgent eligible source. When it can be taken, the block raises `irq_o`.

The handler reads the acknowledge register. That read returns the winning ID and moves the source from pending to active. When the handler is done, it writes the same ID to the end-of-interrupt register. While a source is active, only a strictly more urgent source can raise the line again, so handlers nest. Three controls gate the output: a global forwarding enable, a processor priority threshold and a processor-side enable.

Top module: `icp_ctrl`

## Requirements
- R1: After reset the following all hold. Every enable, priority, target, threshold and both global enables read 0. `irq_o` is low. The configuration words read 0xAAAAAAAA for IDs 0–15 and 0x55555555 for IDs 16–31 and for all IDs from 32 up.
- R2: The priority of source n is held in word 0x20+n/4, in byte lane n mod 4. Only bits 7:3 are stored and bits 2:0 read 0. A lower value is more urgent.
- R3: The 2-bit configuration of source n is held in word 0x18+n/16, at bit 2·(n mod 16). 01 means a level source and 11 means a rising-edge source, so bit 1 selects edge. For n < 32 the field is read-only: 10 for IDs 0–15, which are edge sources, and 01 for IDs 16–31. For n ≥ 32 only bit 1 is writable.
- R4: The target byte of source n is held in word 0x40+n/4, in byte lane n mod 4. For n < 32 it reads 0 and writes are ignored.
- R5: Enables use one bit per source, bit n mod 32. Writing a 1 to word 0x08+n/32 sets the enable. Writing a 1 to word 0x10+n/32 clears it. Both words read back the enable mask.
- R6: A read of word 0x03 takes effect on the strobe edge, and its data is valid on `bus_rdata_o` from that edge onward. Bits 9:0 give the eligible source with the lowest priority value, with ties going to the lowest ID. The read makes that source active.
- R7: An acknowledge read returns 1023 when `irq_o` is low, and it then changes no source state.
- R8: A source is eligible only if its priority is strictly below the threshold in word 0x01, bits 7:3. Bits 2:0 of that word read 0.
- R9: `irq_o` and a non-spurious acknowledge need two things: bit 0 of word 0x00 (forwarding enable) and bit 0 of word 0x02 (processor enable).
- R10: While any source is active, the winner must be strictly more urgent than the most urgent active source.
- R11: Writing ID n to word 0x04 clears active for source n. Values of `NSRC` or above are ignored.
- R12: A level source is pending while its input is high and it is not active. An edge source latches pending one cycle after a 0-to-1 input change, keeps it after the input drops, and loses it on acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| src_i | input | NSRC | Interrupt source inputs |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 8 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after the read strobe |
| irq_o | output | 1 | Processor interrupt request |

## Verification
The hardest state to reach is a nested stack of active sources. Reaching it needs a low-urgency source acknowledged first, then a more urgent one taken on top of it. The end-of-interrupt writes must then unwind the stack in an order that shows equal-priority sources stay blocked. The stimulus raises three level inputs with two of them tied in priority. It acknowledges the tie winner, brings a priority-0 source on top, and retires the stack one level at a time, checking after each write which ID comes out next. Edge sources are pulsed while the same source is still active, to show that the latch survives and stays masked until its own end-of-interrupt.

// File: rtl/icp_pkg.sv
package icp_pkg;
    localparam int REG_W    = 32;
    localparam int ADDR_W   = 8;
    localparam int ID_W     = 10;
    localparam int PRI_W    = 5;
    localparam int SGI_IDS  = 16;
    localparam int FIXED_IDS = 32;
    localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

    localparam logic [ADDR_W-1:0] A_DCTL  = 8'h00;
    localparam logic [ADDR_W-1:0] A_PMASK = 8'h01;
    localparam logic [ADDR_W-1:0] A_CCTL  = 8'h02;
    localparam logic [ADDR_W-1:0] A_ACK   = 8'h03;
    localparam logic [ADDR_W-1:0] A_EOI   = 8'h04;
    localparam logic [ADDR_W-1:0] A_ENSET = 8'h08;
    localparam logic [ADDR_W-1:0] A_ENCLR = 8'h10;
    localparam logic [ADDR_W-1:0] A_CFG   = 8'h18;
    localparam logic [ADDR_W-1:0] A_PRI   = 8'h20;
    localparam logic [ADDR_W-1:0] A_TGT   = 8'h40;

    function automatic logic in_win(input logic [ADDR_W-1:0] a,
                                    input logic [ADDR_W-1:0] base, input int n);
        return (a >= base) && (int'(a) < int'(base) + n);
    endfunction
endpackage

// File: rtl/icp_select.sv
module icp_select #(
    parameter int N  = 64,
    parameter int PW = 5,
    parameter int IW = 6
) (
    input  logic [N-1:0]         req_i,
    input  logic [N-1:0][PW-1:0] pri_i,
    output logic                 found_o,
    output logic [IW-1:0]        id_o,
    output logic [PW-1:0]        pri_o
);
    always_comb begin
        found_o = 1'b0;
        id_o    = '0;
        pri_o   = '1;
        for (int i = 0; i < N; i++) begin
            // strict compare keeps the lowest index on a tie
            if (req_i[i] && (!found_o || (pri_i[i] < pri_o))) begin
                found_o = 1'b1;
                id_o    = IW'(i);
                pri_o   = pri_i[i];
            end
        end
    end
endmodule

// File: rtl/icp_ctrl.sv
module icp_ctrl
    import icp_pkg::*;
#(
    parameter int NSRC = 64
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NSRC-1:0]   src_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [7:0]        bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    output logic              irq_o
);
    localparam int IW   = $clog2(NSRC);
    localparam int NW32 = NSRC / 32;
    localparam int NW16 = NSRC / 16;
    localparam int NW4  = NSRC / 4;

    typedef struct packed {
        logic                        dist_en;
        logic                        cpu_en;
        logic [PRI_W-1:0]            mask;
        logic [NSRC-1:0]             en;
        logic [NSRC-1:0]             epend;
        logic [NSRC-1:0]             act;
        logic [NSRC-1:0]             prev;
        logic [NSRC-1:0]             edge_cfg;
        logic [NSRC-1:0][PRI_W-1:0]  pri;
        logic [NSRC-1:0][7:0]        tgt;
        logic [REG_W-1:0]            rdata;
    } state_t;

    function automatic state_t reset_state();
        state_t r;
        r = '0;
        for (int i = 0; i < SGI_IDS; i++) r.edge_cfg[i] = 1'b1;
        return r;
    endfunction

    state_t s_q, s_d;

    logic [NSRC-1:0] pend, elig;
    logic            win_found, run_found, fire;
    logic [IW-1:0]   win_id, run_id;
    logic [PRI_W-1:0] win_pri, run_pri;
    logic            ack_rd, eoi_wr;
    logic [ADDR_W-1:0] w;
    logic [REG_W-1:0] rd_val;
    logic [IW-1:0]   idx;

    always_comb begin
        for (int i = 0; i < NSRC; i++) begin
            pend[i] = s_q.edge_cfg[i] ? s_q.epend[i] : (src_i[i] & ~s_q.act[i]);
            elig[i] = pend[i] & s_q.en[i] & (s_q.pri[i] < s_q.mask);
        end
    end

    icp_select #(.N(NSRC), .PW(PRI_W), .IW(IW)) u_win (
        .req_i(elig), .pri_i(s_q.pri), .found_o(win_found), .id_o(win_id), .pri_o(win_pri));

    icp_select #(.N(NSRC), .PW(PRI_W), .IW(IW)) u_run (
        .req_i(s_q.act), .pri_i(s_q.pri), .found_o(run_found), .id_o(run_id), .pri_o(run_pri));

    assign fire   = s_q.dist_en & s_q.cpu_en & win_found & (!run_found || (win_pri < run_pri));
    assign irq_o  = fire;
    assign ack_rd = bus_rd_i && (bus_addr_i == A_ACK);
    assign eoi_wr = bus_wr_i && (bus_addr_i == A_EOI);
    assign bus_rdata_o = s_q.rdata;

    // register read mux
    always_comb begin
        rd_val = '0;
        w      = '0;
        idx    = '0;
        if (bus_addr_i == A_DCTL) rd_val[0] = s_q.dist_en;
        else if (bus_addr_i == A_PMASK) rd_val[7:3] = s_q.mask;
        else if (bus_addr_i == A_CCTL) rd_val[0] = s_q.cpu_en;
        else if (in_win(bus_addr_i, A_ENSET, NW32) || in_win(bus_addr_i, A_ENCLR, NW32)) begin
            w = (bus_addr_i >= A_ENCLR) ? bus_addr_i - A_ENCLR : bus_addr_i - A_ENSET;
            for (int b = 0; b < 32; b++) begin
                idx = IW'(int'(w) * 32 + b);
                rd_val[b] = s_q.en[idx];
            end
        end else if (in_win(bus_addr_i, A_CFG, NW16)) begin
            w = bus_addr_i - A_CFG;
            for (int b = 0; b < 16; b++) begin
                idx = IW'(int'(w) * 16 + b);
                if (int'(idx) < SGI_IDS)        rd_val[2*b +: 2] = 2'b10;
                else if (int'(idx) < FIXED_IDS) rd_val[2*b +: 2] = 2'b01;
                else                            rd_val[2*b +: 2] = {s_q.edge_cfg[idx], 1'b1};
            end
        end else if (in_win(bus_addr_i, A_PRI, NW4)) begin
            w = bus_addr_i - A_PRI;
            for (int b = 0; b < 4; b++) begin
                idx = IW'(int'(w) * 4 + b);
                rd_val[8*b+3 +: 5] = s_q.pri[idx];
            end
        end else if (in_win(bus_addr_i, A_TGT, NW4)) begin
            w = bus_addr_i - A_TGT;
            for (int b = 0; b < 4; b++) begin
                idx = IW'(int'(w) * 4 + b);
                rd_val[8*b +: 8] = s_q.tgt[idx];
            end
        end
    end

    // next-state logic
    always_comb begin
        logic [NSRC-1:0]  ack_clr;
        logic [ADDR_W-1:0] wo;
        logic [IW-1:0]    id;
        s_d     = s_q;
        ack_clr = '0;
        wo      = '0;
        id      = '0;
        s_d.prev = src_i;
        if (ack_rd) begin
            s_d.rdata = fire ? REG_W'(win_id) : REG_W'(SPURIOUS_ID);
            if (fire) begin
                s_d.act[win_id] = 1'b1;
                ack_clr[win_id] = 1'b1;
            end
        end else if (bus_rd_i) begin
            s_d.rdata = rd_val;
        end
        s_d.epend = (s_q.epend & ~ack_clr) | (src_i & ~s_q.prev & s_q.edge_cfg);
        if (bus_wr_i) begin
            if (bus_addr_i == A_DCTL) s_d.dist_en = bus_wdata_i[0];
            else if (bus_addr_i == A_PMASK) s_d.mask = bus_wdata_i[7:3];
            else if (bus_addr_i == A_CCTL) s_d.cpu_en = bus_wdata_i[0];
            else if (eoi_wr) begin
                if (int'(bus_wdata_i[ID_W-1:0]) < NSRC) s_d.act[bus_wdata_i[IW-1:0]] = 1'b0;
            end else if (in_win(bus_addr_i, A_ENSET, NW32)) begin
                wo = bus_addr_i - A_ENSET;
                for (int b = 0; b < 32; b++) begin
                    id = IW'(int'(wo) * 32 + b);
                    if (bus_wdata_i[b]) s_d.en[id] = 1'b1;
                end
            end else if (in_win(bus_addr_i, A_ENCLR, NW32)) begin
                wo = bus_addr_i - A_ENCLR;
                for (int b = 0; b < 32; b++) begin
                    id = IW'(int'(wo) * 32 + b);
                    if (bus_wdata_i[b]) s_d.en[id] = 1'b0;
                end
            end else if (in_win(bus_addr_i, A_CFG, NW16)) begin
                wo = bus_addr_i - A_CFG;
                for (int b = 0; b < 16; b++) begin
                    id = IW'(int'(wo) * 16 + b);
                    if (int'(id) >= FIXED_IDS) s_d.edge_cfg[id] = bus_wdata_i[2*b+1];
                end
            end else if (in_win(bus_addr_i, A_PRI, NW4)) begin
                wo = bus_addr_i - A_PRI;
                for (int b = 0; b < 4; b++) begin
                    id = IW'(int'(wo) * 4 + b);
                    s_d.pri[id] = bus_wdata_i[8*b+3 +: 5];
                end
            end else if (in_win(bus_addr_i, A_TGT, NW4)) begin
                wo = bus_addr_i - A_TGT;
                for (int b = 0; b < 4; b++) begin
                    id = IW'(int'(wo) * 4 + b);
                    if (int'(id) >= FIXED_IDS) s_d.tgt[id] = bus_wdata_i[8*b +: 8];
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= reset_state();
        else         s_q <= s_d;
    end

    // R8
    mask_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (win_pri < s_q.mask));

    // R10
    preempt_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_o && run_found) |-> (win_pri < run_pri));

    // R6
    ack_activates_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_rd && fire && !bus_wr_i) |=> s_q.act[$past(win_id)]);

    // R7
    spurious_id_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_rd && !fire) |=> (bus_rdata_o == REG_W'(SPURIOUS_ID)));

    // R9
    gate_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!s_q.dist_en || !s_q.cpu_en) |-> !irq_o);

    // R10
    run_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_found |-> s_q.act[run_id]);
endmodule

// File: tb/icp_ctrl_tb_top.sv
module icp_ctrl_tb_top;
    localparam int CLK_NS = 10;
    localparam int NSRC   = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] src = '0;
    logic            wr = 1'b0, rd = 1'b0;
    logic [7:0]      addr = '0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic            irq;

    int checks = 0, fails = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;
    bit          done = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    icp_ctrl #(.NSRC(NSRC)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .src_i(src), .bus_wr_i(wr), .bus_rd_i(rd),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq));

    always @(posedge clk) rd_seen <= rd;

    // monitor: compare read data against the scoreboard
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (rdata !== e) begin
                fails++;
                $display("FAIL %s rdata actual=%08h expected=%08h", t, rdata, e);
            end
        end
    end

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, input logic [31:0] e, input string t);
        @(negedge clk); rd = 1'b1; addr = a;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk); rd = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string t);
        @(negedge clk);
        checks++;
        if (irq !== e) begin
            fails++;
            $display("FAIL %s irq actual=%0b expected=%0b", t, irq, e);
        end
    endtask

    task automatic set_src(input int id, input logic v);
        @(negedge clk); src[id] = v;
    endtask

    task automatic pulse_src(input int id);
        @(negedge clk); src[id] = 1'b1;
        @(negedge clk); src[id] = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk_irq(1'b0, "R1");
        rd_reg(8'h00, 32'h0, "R1");
        rd_reg(8'h02, 32'h0, "R1");
        rd_reg(8'h01, 32'h0, "R1");
        rd_reg(8'h09, 32'h0, "R1");
        rd_reg(8'h28, 32'h0, "R1");
        rd_reg(8'h18, 32'hAAAAAAAA, "R1");
        rd_reg(8'h19, 32'h55555555, "R1");
        rd_reg(8'h1A, 32'h55555555, "R1");
        rd_reg(8'h03, 32'd1023, "R7");
        // R2 priority storage
        wr_reg(8'h29, 32'hFFFFFFFF);
        rd_reg(8'h29, 32'hF8F8F8F8, "R2");
        // R8 threshold low bits
        wr_reg(8'h01, 32'h4F);
        rd_reg(8'h01, 32'h48, "R8");
        // setup nesting scenario
        wr_reg(8'h00, 32'h1);
        wr_reg(8'h02, 32'h1);
        wr_reg(8'h01, 32'hF8);
        wr_reg(8'h28, 32'hF8F840F8);   // id33 = 0x40
        wr_reg(8'h2A, 32'hF8F82020);   // id40, id41 = 0x20
        wr_reg(8'h09, 32'h302);        // enable 33,40,41
        rd_reg(8'h11, 32'h302, "R5");
        set_src(33, 1'b1); set_src(40, 1'b1); set_src(41, 1'b1);
        chk_irq(1'b1, "R12");
        rd_reg(8'h03, 32'd40, "R6");          // tie 40/41 -> 40
        chk_irq(1'b0, "R10");
        rd_reg(8'h03, 32'd1023, "R7");
        wr_reg(8'h28, 32'hF80040F8);   // id34 = 0
        wr_reg(8'h09, 32'h4);
        set_src(34, 1'b1);
        chk_irq(1'b1, "R10");
        rd_reg(8'h03, 32'd34, "R10");
        chk_irq(1'b0, "R10");
        set_src(34, 1'b0);
        wr_reg(8'h04, 32'd34);
        chk_irq(1'b0, "R11");                 // 40 still active, 41 equal
        set_src(40, 1'b0);
        wr_reg(8'h04, 32'd40);
        chk_irq(1'b1, "R11");
        rd_reg(8'h03, 32'd41, "R11");
        chk_irq(1'b0, "R10");
        set_src(41, 1'b0);
        wr_reg(8'h04, 32'd41);
        rd_reg(8'h03, 32'd33, "R6");
        chk_irq(1'b0, "R12");                 // level source active
        wr_reg(8'h04, 32'd33);
        chk_irq(1'b1, "R12");                 // still high -> pending again
        // R8 threshold strictness
        wr_reg(8'h01, 32'h40);
        chk_irq(1'b0, "R8");
        wr_reg(8'h01, 32'h48);
        chk_irq(1'b1, "R8");
        // R9 forwarding enable
        wr_reg(8'h00, 32'h0);
        chk_irq(1'b0, "R9");
        rd_reg(8'h03, 32'd1023, "R9");
        wr_reg(8'h00, 32'h1);
        chk_irq(1'b1, "R9");
        // R5 enable clear
        wr_reg(8'h11, 32'h2);
        chk_irq(1'b0, "R5");
        rd_reg(8'h09, 32'h304, "R5");
        // R3 edge configuration
        wr_reg(8'h1A, 32'h02000000);
        rd_reg(8'h1A, 32'h57555555, "R3");
        wr_reg(8'h2B, 32'hF8F8F810);   // id44 = 0x10
        wr_reg(8'h09, 32'h1000);
        wr_reg(8'h01, 32'hF8);
        pulse_src(44);
        chk_irq(1'b1, "R12");                 // latched after input dropped
        rd_reg(8'h03, 32'd44, "R12");
        chk_irq(1'b0, "R12");
        wr_reg(8'h04, 32'd100);               // out of range, ignored
        pulse_src(44);
        chk_irq(1'b0, "R11");                 // 44 still active
        wr_reg(8'h04, 32'd44);
        chk_irq(1'b1, "R11");
        rd_reg(8'h03, 32'd44, "R12");
        wr_reg(8'h04, 32'd44);
        chk_irq(1'b0, "R12");
        // R9 processor enable
        wr_reg(8'h02, 32'h0);
        pulse_src(44);
        chk_irq(1'b0, "R9");
        rd_reg(8'h03, 32'd1023, "R9");
        wr_reg(8'h02, 32'h1);
        chk_irq(1'b1, "R9");
        rd_reg(8'h03, 32'd44, "R9");
        wr_reg(8'h04, 32'd44);
        // R4 targets and R3 fixed fields
        wr_reg(8'h48, 32'h01020304);
        rd_reg(8'h48, 32'h01020304, "R4");
        wr_reg(8'h40, 32'hFFFFFFFF);
        rd_reg(8'h40, 32'h0, "R4");
        wr_reg(8'h19, 32'h0);
        rd_reg(8'h19, 32'h55555555, "R3");
        wr_reg(8'h18, 32'h0);
        rd_reg(8'h18, 32'hAAAAAAAA, "R3");
        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL scoreboard not drained actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule